// File: doc/BRIEF.md
# Interrupt flag and mask register

This block collects the interrupt requests of a small microcontroller and presents one request line to the CPU core. It has two sources. The first is a falling edge on an active-low external interrupt pin, which is synchronised before edge detection. The second is a single-cycle overflow pulse from the timer. Each source latches a sticky flag bit. A separate mask register selects which flags may raise the request. A global enable bit gates the request line as a whole.

Software uses a one-address-bit register port. Address 0 is the flag register. A read there returns the flags ANDed with the mask. A write there can only clear flags. Address 1 is the mask register, which is plainly readable and writable. The global enable follows event strobes from the core:
- An enable-interrupt or return-from-interrupt event sets it.
- A disable-interrupt event clears it.
- The hardware taking an interrupt clears it.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset the flags, the mask and the global enable are all 0. Reads of address 0 and address 1 both return 0x00, and `irq_req_o` is 0.
- R2: The external flag is bit 3 of the flag register. A 1-to-0 change on `ext_irq_n_i` sets it, and it is first visible after the third rising clock edge that follows the change. A pin that stays low sets the flag only once.
- R3: The timer flag is bit 0 of the flag register. A `tmr_ovf_i` pulse that is high at a rising edge sets the flag at that edge.
- R4: Bits 1, 2 and 4 to 7 of an address-0 read are always 0.
- R5: A write to address 0 clears every flag whose data bit is 0 and leaves unchanged every flag whose data bit is 1. A write never sets a flag.
- R6: If a source sets a flag and a write clears it in the same cycle, the flag ends up set.
- R7: A read of address 0 returns the flags ANDed with the mask. A read of address 1 returns all 8 mask bits as last written.
- R8: `gie_o` becomes 1 after an edge where `ien_set_i` is high. It becomes 0 after an edge where `ien_clr_i` or `irq_take_i` is high. Clearing wins when both kinds of event arrive together.
- R9: `irq_req_o` is 1 exactly when `gie_o` is 1 and at least one flag has its mask bit set.
- R10: A 0-to-1 change on `ext_irq_n_i` never sets a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_irq_n_i | input | 1 | External interrupt pin, active low, asynchronous |
| tmr_ovf_i | input | 1 | Timer overflow pulse |
| ien_set_i | input | 1 | Enable-interrupt or return-from-interrupt event |
| ien_clr_i | input | 1 | Disable-interrupt event |
| irq_take_i | input | 1 | Core has taken an interrupt |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 1 | Register select: 0 flags, 1 mask |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the selected register |
| irq_req_o | output | 1 | Interrupt request to the core |
| gie_o | output | 1 | Global interrupt enable state |

## Verification
The assertions assume that the external pin is high when the internal reset releases. The synchroniser comes out of reset at the idle level, so a pin held low through reset would look like one fresh falling edge. They also rely on the strobes being sampled only at rising edges, with no further limit on how the strobes overlap. The stimulus keeps the pin high through reset and the following idle cycles. After that it drives every strobe, write and pin change from random draws on the falling clock edge. Enable, disable and take events are allowed to collide, and hardware sets are allowed to collide with clearing writes.

// File: rtl/irq_flag_pkg.sv
`timescale 1ns/1ps
package irq_flag_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned N_SRC   = 2;
  localparam int unsigned TMR_POS = 0;
  localparam int unsigned EXT_POS = 3;
  localparam int unsigned SRC_TMR = 0;
  localparam int unsigned SRC_EXT = 1;

  typedef logic [REG_W-1:0] reg_t;

  typedef enum logic {
    ADDR_FLAG = 1'b0,
    ADDR_MASK = 1'b1
  } reg_addr_e;

  localparam int unsigned SRC_POS [N_SRC] = '{TMR_POS, EXT_POS};
  localparam reg_t IMPL_BITS = reg_t'((1 << TMR_POS) | (1 << EXT_POS));
endpackage

// File: rtl/irq_rst_sync.sv
`timescale 1ns/1ps
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] rs_q;
  logic [STAGES-1:0] rs_d;

  always_comb begin
    rs_d = {rs_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rs_q <= '0;
    end else begin
      rs_q <= rs_d;
    end
  end

  assign rst_n_o = rs_q[STAGES-1];
endmodule

// File: rtl/irq_edge_fall.sv
`timescale 1ns/1ps
module irq_edge_fall #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   prev_q;
  logic                   prev_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], pin_i};
    prev_d = sync_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign fall_o = prev_q & ~sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/irq_flag_bank.sv
`timescale 1ns/1ps
module irq_flag_bank #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_en_i,
  input  logic [N-1:0] keep_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;
  logic [N-1:0] flag_d;
  logic [N-1:0] flag_en;

  always_comb begin
    for (int i = 0; i < int'(N); i++) begin
      flag_en[i] = set_i[i] | clr_en_i;
      flag_d[i]  = set_i[i] | (flag_q[i] & keep_i[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else begin
      for (int i = 0; i < int'(N); i++) begin
        if (flag_en[i]) begin
          flag_q[i] <= flag_d[i];
        end
      end
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_gie_ctrl.sv
`timescale 1ns/1ps
module irq_gie_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic on_i,
  input  logic off_i,
  output logic gie_o
);
  logic gie_q;
  logic gie_d;
  logic gie_en;

  always_comb begin
    gie_en = on_i | off_i;
    gie_d  = off_i ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q <= 1'b0;
    end else if (gie_en) begin
      gie_q <= gie_d;
    end
  end

  assign gie_o = gie_q;
endmodule

// File: rtl/irq_flag_ctrl.sv
`timescale 1ns/1ps
module irq_flag_ctrl
  import irq_flag_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_irq_n_i,
  input  logic             tmr_ovf_i,
  input  logic             ien_set_i,
  input  logic             ien_clr_i,
  input  logic             irq_take_i,
  input  logic             bus_wr_i,
  input  logic             bus_addr_i,
  input  logic [REG_W-1:0] bus_wdata_i,
  output logic [REG_W-1:0] bus_rdata_o,
  output logic             irq_req_o,
  output logic             gie_o
);
  logic             rst_sync_n;
  logic             ext_fall;
  logic [N_SRC-1:0] src_set;
  logic [N_SRC-1:0] src_keep;
  logic [N_SRC-1:0] src_flag;
  logic             flag_wr;
  logic             mask_wr;
  reg_t             flag_q;
  reg_t             mask_q;
  reg_t             mask_d;
  reg_t             pend;
  reg_addr_e        sel;

  irq_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  irq_edge_fall #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .pin_i  (ext_irq_n_i),
    .fall_o (ext_fall)
  );

  always_comb begin
    sel     = reg_addr_e'(bus_addr_i);
    flag_wr = bus_wr_i & (sel == ADDR_FLAG);
    mask_wr = bus_wr_i & (sel == ADDR_MASK);
    src_set = '0;
    src_set[SRC_TMR] = tmr_ovf_i;
    src_set[SRC_EXT] = ext_fall;
  end

  for (genvar g = 0; g < int'(N_SRC); g++) begin : g_keep
    assign src_keep[g] = bus_wdata_i[SRC_POS[g]];
  end

  irq_flag_bank #(.N(N_SRC)) u_bank (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .set_i    (src_set),
    .clr_en_i (flag_wr),
    .keep_i   (src_keep),
    .flag_o   (src_flag)
  );

  always_comb begin
    flag_q = '0;
    for (int i = 0; i < int'(N_SRC); i++) begin
      flag_q[SRC_POS[i]] = src_flag[i];
    end
  end

  always_comb begin
    mask_d = bus_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mask_q <= '0;
    end else if (mask_wr) begin
      mask_q <= mask_d;
    end
  end

  irq_gie_ctrl u_gie (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .on_i  (ien_set_i),
    .off_i (ien_clr_i | irq_take_i),
    .gie_o (gie_o)
  );

  always_comb begin
    pend = flag_q & mask_q;
    unique case (sel)
      ADDR_FLAG: bus_rdata_o = pend;
      ADDR_MASK: bus_rdata_o = mask_q;
      default:   bus_rdata_o = '0;
    endcase
    irq_req_o = gie_o & (|pend);
  end
endmodule

// File: rtl/irq_flag_chk.sv
`timescale 1ns/1ps
module irq_flag_chk
  import irq_flag_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic tmr_ovf_i,
  input logic ext_fall,
  input logic ien_set_i,
  input logic ien_clr_i,
  input logic irq_take_i,
  input logic bus_wr_i,
  input logic bus_addr_i,
  input reg_t bus_wdata_i,
  input reg_t bus_rdata_o,
  input reg_t flag_q,
  input reg_t mask_q,
  input logic gie_o,
  input logic irq_req_o
);
  assert_ext_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ext_fall |=> flag_q[EXT_POS]);

  assert_tmr_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf_i |=> flag_q[TMR_POS]);

  assert_unused_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr_i == 1'b0) |-> ((bus_rdata_o & ~IMPL_BITS) == '0));

  assert_no_sw_set_tmr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[TMR_POS]) |-> $past(tmr_ovf_i));

  assert_no_sw_set_ext_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[EXT_POS]) |-> $past(ext_fall));

  assert_wr_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && !bus_addr_i && !bus_wdata_i[TMR_POS] && !tmr_ovf_i) |=> !flag_q[TMR_POS]);

  assert_read_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr_i == 1'b0) |-> ((bus_rdata_o & ~mask_q) == '0));

  assert_gie_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_clr_i || irq_take_i) |=> !gie_o);

  assert_gie_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_set_i && !ien_clr_i && !irq_take_i) |=> gie_o);

  assert_req_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> (gie_o && ((flag_q & mask_q) != '0)));
endmodule

bind irq_flag_ctrl irq_flag_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .tmr_ovf_i   (tmr_ovf_i),
  .ext_fall    (ext_fall),
  .ien_set_i   (ien_set_i),
  .ien_clr_i   (ien_clr_i),
  .irq_take_i  (irq_take_i),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .flag_q      (flag_q),
  .mask_q      (mask_q),
  .gie_o       (gie_o),
  .irq_req_o   (irq_req_o)
);

// File: tb/irq_flag_ctrl_tb.sv
`timescale 1ns/1ps
module irq_flag_ctrl_tb;
  logic       clk;
  logic       rst_n;
  logic       ext_irq_n_i;
  logic       tmr_ovf_i;
  logic       ien_set_i;
  logic       ien_clr_i;
  logic       irq_take_i;
  logic       bus_wr_i;
  logic       bus_addr_i;
  logic [7:0] bus_wdata_i;
  logic [7:0] bus_rdata_o;
  logic       irq_req_o;
  logic       gie_o;

  int n_tests;
  int n_fail;
  bit done;

  logic [7:0] m_flag, m_mask;
  logic       m_gie, m_s1, m_s2, m_prev;

  irq_flag_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ext_irq_n_i(ext_irq_n_i), .tmr_ovf_i(tmr_ovf_i),
    .ien_set_i(ien_set_i), .ien_clr_i(ien_clr_i), .irq_take_i(irq_take_i),
    .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .irq_req_o(irq_req_o), .gie_o(gie_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd();
    return bus_addr_i ? m_mask : (m_flag & m_mask);
  endfunction

  function automatic logic exp_req();
    return m_gie & (|(m_flag & m_mask));
  endfunction

  task automatic model_step();
    logic [7:0] nf;
    logic       fall;
    fall = m_prev & ~m_s2;
    nf = m_flag;
    if (bus_wr_i && !bus_addr_i) nf = nf & bus_wdata_i;
    nf[3] = nf[3] | fall;
    nf[0] = nf[0] | tmr_ovf_i;
    nf = nf & 8'h09;
    if (bus_wr_i && bus_addr_i) m_mask = bus_wdata_i;
    if (ien_clr_i || irq_take_i) m_gie = 1'b0;
    else if (ien_set_i) m_gie = 1'b1;
    m_prev = m_s2;
    m_s2   = m_s1;
    m_s1   = ext_irq_n_i;
    m_flag = nf;
  endtask

  task automatic idle();
    tmr_ovf_i = 0; ien_set_i = 0; ien_clr_i = 0; irq_take_i = 0; bus_wr_i = 0;
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R7 model read", bus_rdata_o, exp_rd());
    chk("R9 model req", {7'd0, irq_req_o}, {7'd0, exp_req()});
    chk("R8 model gie", {7'd0, gie_o}, {7'd0, m_gie});
    idle();
  endtask

  task automatic wr(logic a, logic [7:0] d);
    bus_wr_i = 1; bus_addr_i = a; bus_wdata_i = d;
    cycle();
  endtask

  task automatic rd_now(logic a, string tag, logic [7:0] exp);
    bus_addr_i = a;
    #1;
    chk(tag, bus_rdata_o, exp);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0417));
    n_tests = 0; n_fail = 0; done = 0;
    rst_n = 0; ext_irq_n_i = 1; bus_addr_i = 0; bus_wdata_i = 0;
    idle();
    m_flag = 0; m_mask = 0; m_gie = 0; m_s1 = 1; m_s2 = 1; m_prev = 1;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_now(0, "R1 flags after reset", 8'h00);
    rd_now(1, "R1 mask after reset", 8'h00);
    chk("R1 req after reset", {7'd0, irq_req_o}, 8'h00);
    chk("R1 gie after reset", {7'd0, gie_o}, 8'h00);

    wr(1, 8'hFF);
    rd_now(1, "R7 mask readback", 8'hFF);

    // R5 writing ones never sets
    wr(0, 8'hFF);
    rd_now(0, "R5 write ones on clear flags", 8'h00);

    // R3 timer pulse
    tmr_ovf_i = 1; cycle();
    rd_now(0, "R3 timer flag", 8'h01);
    wr(0, 8'hFF);
    rd_now(0, "R5 write one keeps", 8'h01);
    wr(0, 8'hFE);
    rd_now(0, "R5 write zero clears", 8'h00);

    // R2 external edge latency
    ext_irq_n_i = 0;
    cycle(); rd_now(0, "R2 edge +1", 8'h00);
    cycle(); rd_now(0, "R2 edge +2", 8'h00);
    cycle(); rd_now(0, "R2 edge +3", 8'h08);
    wr(0, 8'h00);
    repeat (5) cycle();
    rd_now(0, "R2 held low sets once", 8'h00);

    // R10 rising edge ignored
    ext_irq_n_i = 1;
    repeat (5) cycle();
    rd_now(0, "R10 rising edge", 8'h00);

    // R4 unused bits
    tmr_ovf_i = 1; cycle();
    ext_irq_n_i = 0; repeat (4) cycle();
    rd_now(0, "R4 both flags", 8'h09);
    chk("R4 unused bits", bus_rdata_o & 8'hF6, 8'h00);

    // R6 set beats clear
    tmr_ovf_i = 1; bus_wr_i = 1; bus_addr_i = 0; bus_wdata_i = 8'h00; cycle();
    rd_now(0, "R6 set wins", 8'h01);

    // R7 masking
    tmr_ovf_i = 1; ext_irq_n_i = 1; cycle();
    ext_irq_n_i = 0; repeat (4) cycle();
    wr(1, 8'h08);
    rd_now(0, "R7 masked read", 8'h08);

    // R8 global enable
    ien_set_i = 1; cycle();
    chk("R8 enable", {7'd0, gie_o}, 8'h01);
    ien_set_i = 1; ien_clr_i = 1; cycle();
    chk("R8 clear wins", {7'd0, gie_o}, 8'h00);
    ien_set_i = 1; cycle();
    irq_take_i = 1; cycle();
    chk("R8 take clears", {7'd0, gie_o}, 8'h00);

    // R9 request gating
    wr(0, 8'h01);
    ien_set_i = 1; wr(1, 8'h08);
    chk("R9 masked off", {7'd0, irq_req_o}, 8'h00);
    wr(1, 8'h01);
    chk("R9 request", {7'd0, irq_req_o}, 8'h01);
    ien_clr_i = 1; cycle();
    chk("R9 gie off", {7'd0, irq_req_o}, 8'h00);

    // random phase
    ext_irq_n_i = 1;
    repeat (5) cycle();
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(7) == 0) ext_irq_n_i = ~ext_irq_n_i;
      tmr_ovf_i   = ($urandom_range(15) == 0);
      ien_set_i   = ($urandom_range(15) == 0);
      ien_clr_i   = ($urandom_range(31) == 0);
      irq_take_i  = ($urandom_range(31) == 0);
      bus_wr_i    = ($urandom_range(7) == 0);
      bus_addr_i  = $urandom_range(1);
      bus_wdata_i = 8'($urandom);
      cycle();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule